// File: doc/BRIEF.md
# Local register set call/return cache

This block is a 32-entry general register file. The lower half holds global registers that persist across procedure boundaries. The upper half holds the local registers of the procedure that is running now. An on-chip stack of saved local sets lets procedure calls and returns preserve locals in hardware, without any load or store instructions.

A call strobe copies the whole active local set into the next free stack slot and clears the locals for the callee. The copy moves over a 128-bit internal path in four beats. A return strobe pops the most recent slot and copies it back into the locals, also in four beats. While a transfer runs, the block raises `busy` and refuses instruction-side reads and writes. A call into a full stack is reported on an overflow flag instead of being performed, and a return from an empty stack is reported on an underflow flag. Spilling to external memory is left to surrounding logic.

Top module: `lrs_regfile`

## Requirements
- R1: After synchronous active-high reset, every register reads as zero, `busy`, `ovf_flag`, `unf_flag` and `seq_err` are low, and the stack is empty.
- R2: Each read port returns `regs[addr]` on its data output one clock after the address is sampled at a rising edge where `busy` is low. An instruction write (`wr_en` high, `busy` low) updates `regs[wr_addr]` at that edge.
- R3: An accepted call with fewer than 8 saved sets drives `busy` high for exactly 4 cycles, starting the cycle after the strobe edge. An accepted return with at least one saved set does the same.
- R4: After a call completes, registers 16 to 31 read as zero until they are written.
- R5: A return restores registers 16 to 31 to the values they held when the matching call was accepted. Sets are restored in last-in, first-out order, up to 8 levels deep.
- R6: Registers 0 to 15 are never changed by a call or a return. A global written inside a callee keeps its new value after the return.
- R7: While `busy` is high, `wr_en` has no effect and both read data outputs hold their previous values.
- R8: A call when 8 sets are already saved raises `ovf_flag` for one cycle, does not raise `busy`, and leaves all registers and the stack depth unchanged.
- R9: A return when no set is saved raises `unf_flag` for one cycle, does not raise `busy`, and leaves all registers unchanged.
- R10: A call or return strobe seen while `busy` is high, or call and return strobes together while idle, is ignored and raises `seq_err` for one cycle. An ignored strobe leaves the registers and the stack depth unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Read port A register index |
| rd_data_a | output | 32 | Read port A data, registered |
| rd_addr_b | input | 5 | Read port B register index |
| rd_data_b | output | 32 | Read port B data, registered |
| wr_en | input | 1 | Instruction write enable |
| wr_addr | input | 5 | Instruction write register index |
| wr_data | input | 32 | Instruction write data |
| call_req | input | 1 | Procedure call strobe |
| ret_req | input | 1 | Procedure return strobe |
| busy | output | 1 | Local set transfer in progress |
| ovf_flag | output | 1 | One-cycle pulse: call refused, stack full |
| unf_flag | output | 1 | One-cycle pulse: return refused, stack empty |
| seq_err | output | 1 | One-cycle pulse: strobe ignored |

## Verification
A depth counter that is off by one shows up at the ports within one call or return. Either the overflow or underflow flag fires one level early or late, or a return restores the locals of the wrong procedure level. That wrong set is visible on the first read after `busy` falls. A wrong beat count or a wrong beat-to-register mapping leaves some locals stale, swapped or nonzero after a call. Each of these is caught by a full read-back of all 32 registers after every transfer. A transfer that leaks into the global half, or an instruction write that slips through while `busy` is high, is caught the same way at the next read-back.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_SPILL = 2'd1,
    OP_FILL  = 2'd2
  } xfer_op_e;
endpackage

// File: rtl/lrs_set_stack.sv
// Storage for saved local sets: one write port, one registered read port,
// no reset on the array so it maps onto block RAM.
module lrs_set_stack #(
  parameter int W  = 128,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lrs_seq.sv
// Call/return sequencer: accepts strobes, tracks stack depth, walks beats.
module lrs_seq
  import lrs_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int BEATS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic call_req,
  input  logic ret_req,
  output xfer_op_e op,
  output logic [$clog2(BEATS)-1:0] beat,
  output logic busy,
  output logic ram_we,
  output logic [$clog2(SLOTS)+$clog2(BEATS)-1:0] ram_waddr,
  output logic [$clog2(SLOTS)+$clog2(BEATS)-1:0] ram_raddr,
  output logic ovf,
  output logic unf,
  output logic err
);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int BEAT_W  = $clog2(BEATS);
  localparam int DEPTH_W = $clog2(SLOTS + 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic [DEPTH_W-1:0] depth;
  logic [DEPTH_W-1:0] depth_dec;
  logic [SLOT_W-1:0]  slot;
  logic idle, full, empty, take_call, take_ret;

  assign idle      = (op == OP_IDLE);
  assign full      = (depth == DEPTH_W'(SLOTS));
  assign empty     = (depth == '0);
  assign depth_dec = depth - DEPTH_W'(1);
  assign take_call = idle && call_req && !ret_req;
  assign take_ret  = idle && ret_req && !call_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      op    <= OP_IDLE;
      depth <= '0;
      slot  <= '0;
      beat  <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
      err   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      err <= (!idle && (call_req || ret_req)) || (idle && call_req && ret_req);
      if (idle) begin
        if (take_call) begin
          if (full) ovf <= 1'b1;
          else begin
            op   <= OP_SPILL;
            slot <= depth[SLOT_W-1:0];
            beat <= '0;
          end
        end else if (take_ret) begin
          if (empty) unf <= 1'b1;
          else begin
            op    <= OP_FILL;
            slot  <= depth_dec[SLOT_W-1:0];
            depth <= depth_dec;
            beat  <= '0;
          end
        end
      end else if (beat == LAST_BEAT) begin
        op <= OP_IDLE;
        if (op == OP_SPILL) depth <= depth + DEPTH_W'(1);
      end else begin
        beat <= beat + BEAT_W'(1);
      end
    end
  end

  assign busy      = !idle;
  assign ram_we    = (op == OP_SPILL);
  assign ram_waddr = {slot, beat};
  // Read address runs one beat ahead so the registered RAM output
  // lands in the locals on the matching beat edge.
  assign ram_raddr = (op == OP_FILL) ? {slot, beat + BEAT_W'(1)}
                                     : {depth_dec[SLOT_W-1:0], BEAT_W'(0)};

  a_r3_busy_ends: assert property (@(posedge clk) disable iff (rst)
    (!idle && beat == LAST_BEAT) |=> idle);
  a_r3_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (!idle && beat != LAST_BEAT) |=> (op == $past(op)));
  a_r8_depth_bound: assert property (@(posedge clk) disable iff (rst)
    depth <= DEPTH_W'(SLOTS));
  a_r8_ovf_only_full: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (full && idle && $stable(depth)));
  a_r9_unf_only_empty: assert property (@(posedge clk) disable iff (rst)
    unf |-> (empty && idle));
  a_r10_err_has_cause: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(call_req || ret_req));
endmodule

// File: rtl/lrs_regfile.sv
// Register file with hardware save/restore of the local half.
module lrs_regfile
  import lrs_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int NLOC  = 16,
  parameter int BUS_W = 128,
  parameter int SLOTS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREG)-1:0]  rd_addr_a,
  output logic [XLEN-1:0]          rd_data_a,
  input  logic [$clog2(NREG)-1:0]  rd_addr_b,
  output logic [XLEN-1:0]          rd_data_b,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_addr,
  input  logic [XLEN-1:0]          wr_data,
  input  logic                     call_req,
  input  logic                     ret_req,
  output logic                     busy,
  output logic                     ovf_flag,
  output logic                     unf_flag,
  output logic                     seq_err
);
  localparam int NGLOB    = NREG - NLOC;
  localparam int AW       = $clog2(NREG);
  localparam int PER_BEAT = BUS_W / XLEN;
  localparam int BEATS    = NLOC / PER_BEAT;
  localparam int BEAT_W   = $clog2(BEATS);
  localparam int RAM_AW   = $clog2(SLOTS) + BEAT_W;

  logic [XLEN-1:0]   regs [NREG];
  xfer_op_e          op;
  logic [BEAT_W-1:0] beat;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr, ram_raddr;
  logic [BUS_W-1:0]  spill_word, fill_word;
  logic [AW-1:0]     base_idx;

  lrs_seq #(.SLOTS(SLOTS), .BEATS(BEATS)) u_seq (
    .clk(clk), .rst(rst), .call_req(call_req), .ret_req(ret_req),
    .op(op), .beat(beat), .busy(busy), .ram_we(ram_we),
    .ram_waddr(ram_waddr), .ram_raddr(ram_raddr),
    .ovf(ovf_flag), .unf(unf_flag), .err(seq_err)
  );

  lrs_set_stack #(.W(BUS_W), .AW(RAM_AW)) u_stack (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(spill_word),
    .raddr(ram_raddr), .rdata(fill_word)
  );

  // First register of the current beat; lower registers move first.
  assign base_idx = AW'(NGLOB + int'(beat) * PER_BEAT);

  for (genvar j = 0; j < PER_BEAT; j++) begin : g_pack
    assign spill_word[j*XLEN +: XLEN] = regs[base_idx + AW'(j)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (busy) begin
      for (int j = 0; j < PER_BEAT; j++)
        regs[base_idx + AW'(j)] <= (op == OP_FILL) ? fill_word[j*XLEN +: XLEN] : '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_a <= '0;
      rd_data_b <= '0;
    end else if (!busy) begin
      rd_data_a <= regs[rd_addr_a];
      rd_data_b <= regs[rd_addr_b];
    end
  end

  logic [NGLOB*XLEN-1:0] glob_vec;
  logic [NLOC*XLEN-1:0]  loc_vec;
  for (genvar g = 0; g < NGLOB; g++) begin : g_gv
    assign glob_vec[g*XLEN +: XLEN] = regs[g];
  end
  for (genvar l = 0; l < NLOC; l++) begin : g_lv
    assign loc_vec[l*XLEN +: XLEN] = regs[NGLOB + l];
  end

  a_r6_globals_kept: assert property (@(posedge clk) disable iff (rst)
    busy |=> (glob_vec == $past(glob_vec)));
  a_r4_locals_clear: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SPILL && beat == BEAT_W'(BEATS - 1)) |=> (loc_vec == '0));
  a_r7_read_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(rd_data_a) && $stable(rd_data_b)));
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_flag, unf_flag, busy && $rose(busy) && seq_err}));
endmodule

// File: tb/test_lrs_regfile.sv
`timescale 1ns/1ps
module test_lrs_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic [31:0] rd_data_a, rd_data_b, wr_data;
  logic        wr_en, call_req, ret_req;
  logic        busy, ovf_flag, unf_flag, seq_err;

  always #4 clk = ~clk;

  lrs_regfile i_lrs_regfile (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .call_req(call_req), .ret_req(ret_req),
    .busy(busy), .ovf_flag(ovf_flag), .unf_flag(unf_flag), .seq_err(seq_err)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] m_regs [32];
  logic [31:0] m_stk  [8][16];
  int          m_depth;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_regs[a] = d;
  endtask

  task automatic verify_all(input string req);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      rd_addr_a = 5'(i); rd_addr_b = 5'(31 - i);
      @(negedge clk);
      chk(rd_data_a == m_regs[i], req, rd_data_a, m_regs[i]);
      chk(rd_data_b == m_regs[31 - i], req, rd_data_b, m_regs[31 - i]);
    end
  endtask

  // Issue one strobe and watch 8 cycles after its edge.
  task automatic strobe(input bit is_call, output int nbusy, output bit so,
                        output bit su, output bit se);
    nbusy = 0; so = 0; su = 0; se = 0;
    @(negedge clk);
    call_req = is_call; ret_req = !is_call;
    @(negedge clk);
    call_req = 1'b0; ret_req = 1'b0;
    for (int k = 0; k < 8; k++) begin
      nbusy += int'(busy); so |= ovf_flag; su |= unf_flag; se |= seq_err;
      @(negedge clk);
    end
  endtask

  task automatic model_call();
    for (int i = 0; i < 16; i++) begin
      m_stk[m_depth][i] = m_regs[16 + i];
      m_regs[16 + i] = '0;
    end
    m_depth++;
  endtask

  task automatic model_ret();
    m_depth--;
    for (int i = 0; i < 16; i++) m_regs[16 + i] = m_stk[m_depth][i];
  endtask

  task automatic t_reset();
    rst = 1'b1; wr_en = 0; call_req = 0; ret_req = 0;
    rd_addr_a = 0; rd_addr_b = 0; wr_addr = 0; wr_data = 0;
    for (int i = 0; i < 32; i++) m_regs[i] = '0;
    m_depth = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !ovf_flag && !unf_flag && !seq_err, "R1 flags",
        {busy, ovf_flag, unf_flag, seq_err}, 0);
    verify_all("R1 reset zero");
  endtask

  task automatic t_basic_rw();
    for (int i = 0; i < 32; i++) wr(i, 32'hC0DE0000 + 32'(i * 17));
    verify_all("R2 write/read");
  endtask

  task automatic t_nested_calls();
    int nb; bit so, su, se;
    for (int lvl = 0; lvl < 8; lvl++) begin
      strobe(1, nb, so, su, se);
      chk(nb == 4 && !so, "R3 call busy", 32'(nb), 4);
      model_call();
      verify_all("R4 locals cleared");
      for (int i = 16; i < 32; i += 3) wr(i, 32'(lvl * 4096 + i * 5 + 1));
      wr(lvl, 32'hF00D0000 + 32'(lvl));
    end
    strobe(1, nb, so, su, se);
    chk(so && nb == 0, "R8 overflow", {31'(nb), so}, 1);
    verify_all("R8 unchanged");
  endtask

  task automatic t_nested_returns();
    int nb; bit so, su, se;
    for (int lvl = 0; lvl < 8; lvl++) begin
      strobe(0, nb, so, su, se);
      chk(nb == 4 && !su, "R3 return busy", 32'(nb), 4);
      model_ret();
      verify_all("R5 R6 restore");
    end
    strobe(0, nb, so, su, se);
    chk(su && nb == 0, "R9 underflow", {31'(nb), su}, 1);
    verify_all("R9 unchanged");
  endtask

  task automatic t_busy_blocking();
    int nb; bit so, su, se;
    logic [31:0] held;
    @(negedge clk);
    rd_addr_a = 5'd20;
    @(negedge clk);
    held = rd_data_a;
    call_req = 1'b1;
    @(negedge clk);
    call_req = 1'b0;
    ret_req = 1'b1; wr_en = 1'b1; wr_addr = 5'd17; wr_data = 32'hDEADBEEF;
    rd_addr_a = 5'd3;
    @(negedge clk);
    ret_req = 1'b0; wr_en = 1'b0;
    chk(seq_err && busy, "R10 strobe while busy", {busy, seq_err}, 2'b11);
    chk(rd_data_a == held, "R7 read hold", rd_data_a, held);
    @(negedge clk);
    chk(!seq_err, "R10 pulse width", seq_err, 0);
    while (busy) @(negedge clk);
    model_call();
    verify_all("R7 write blocked");
    strobe(0, nb, so, su, se);
    chk(nb == 4, "R5 single return", 32'(nb), 4);
    model_ret();
    verify_all("R5 restore after block");
  endtask

  task automatic t_both_strobes();
    int nb; bit so, su, se;
    @(negedge clk);
    call_req = 1'b1; ret_req = 1'b1;
    @(negedge clk);
    call_req = 1'b0; ret_req = 1'b0;
    chk(seq_err && !busy, "R10 both strobes", {busy, seq_err}, 1);
    strobe(0, nb, so, su, se);
    chk(su && nb == 0, "R10 depth kept", {31'(nb), su}, 1);
    verify_all("R10 regs kept");
  endtask

  initial begin
    t_reset();
    t_basic_rw();
    t_nested_calls();
    t_nested_returns();
    t_busy_blocking();
    t_both_strobes();
    summary();
  end
endmodule